// File: doc/BRIEF.md
# Operand Readiness Scoreboard

This block tracks, for each architectural register of an in-order core, how long the result most recently issued to that register still needs before a consumer may use it. The producer port names a destination register and a producer class. The block loads a countdown for that register and remembers the class. Up to three candidate consumer operands are presented each cycle. Each operand carries a register index and a use type: an early operand, a late ALU operand, store data, or a multiply accumulator. The block answers combinationally whether each operand is ready and whether the consumer must stall.

The wait is not one fixed latency per producer. It is looked up in a table indexed by producer class and consumer use. A register's countdown therefore serves every use type: the block compares it against a threshold derived from that table. Only timing is modelled. Data values and forwarding paths are not.

Each register entry is a two-state machine. S_IDLE means the result is fully settled and the count is zero. S_WAIT means the countdown is running. The entry moves from S_IDLE to S_WAIT when a producer with full latency above one issues to it. It stays in S_IDLE when a move issues to it, since the count loaded is zero. In S_WAIT a new issue reloads the count: the entry stays in S_WAIT, or returns to S_IDLE for a move. Without an issue, it returns to S_IDLE when the count reaches one.

Top module: `latency_scoreboard`

## Requirements
- R1: After reset every register is settled: with no producer issuing, every valid source operand is reported ready and `stall` is low.
- R2: Timing rule and use codes. A consumer presented k cycles after its producer's issue cycle is ready exactly when k is at least the latency for that producer class and use. The use codes are 0 early, 1 late ALU, 2 store data and 3 accumulator. For the ALU class (code 0) the latencies are early 2, late 1, store 0 and accumulator 2.
- R3: Move class (code 1): early 1, late 0, store 0, accumulator 1.
- R4: Single-result multiply (code 2, full latency 6) and halfword multiply (code 3, full latency 5): late 4, accumulator 1, early and store use the full latency.
- R5: Long multiply (code 4, full latency 7) and dual-accumulate-long (code 5, full latency 6): late 4; every other use waits the full latency, including the accumulator.
- R6: Single or double load (code 6): late 2, every other use 3. Load multiple (code 7): late 4, every other use 5.
- R7: Call (code 8) makes its destination wait 32 cycles for every use.
- R8: When the producer issuing in the current cycle writes a source's register, that producer alone decides readiness. The source is ready in the same cycle only if the table latency is 0.
- R9: A second issue to a register replaces the earlier producer's countdown and class, even when the earlier one has not finished.
- R10: A source whose valid bit is low is reported ready. `stall` is high exactly when some source is not ready. Class codes 9 to 15 behave as the ALU class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_valid | input | 1 | A producer issues this cycle |
| prod_reg | input | 4 | Destination register of the producer |
| prod_class | input | 4 | Producer class code |
| src_valid | input | 3 | Per-source valid bits |
| src_reg | input | 12 | Source register indices, 4 bits per source |
| src_use | input | 6 | Source use codes, 2 bits per source |
| src_ready | output | 3 | Per-source readiness |
| stall | output | 1 | Consumer must wait |

## Verification
Two functions of the block can meet in one cycle. The first is a fresh producer issue that reloads a register's entry. The second is a consumer lookup of that same register, whose result must then come from the new producer rather than the old countdown. Random stimulus provokes this by drawing producer and source registers from a narrow index range. Directed sequences also issue a slow producer followed quickly by a fast one to the same register. Every cycle the bench rebuilds the expected readiness from its own record of issue cycles and classes and the latency table. It judges a same-cycle match only by whether the table latency is zero.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int LAT_W = 6;

    typedef enum logic [3:0] {
        PC_ALU   = 4'd0,
        PC_MOV   = 4'd1,
        PC_MUL   = 4'd2,
        PC_MULH  = 4'd3,
        PC_MULL  = 4'd4,
        PC_MLALD = 4'd5,
        PC_LD    = 4'd6,
        PC_LDM   = 4'd7,
        PC_CALL  = 4'd8
    } pclass_e;

    typedef enum logic [1:0] {
        CU_EARLY = 2'd0,
        CU_LATE  = 2'd1,
        CU_STORE = 2'd2,
        CU_ACC   = 2'd3
    } cuse_e;

    // Longest wait a producer class can impose on any use.
    function automatic logic [LAT_W-1:0] full_lat(input logic [3:0] cls);
        logic [LAT_W-1:0] r;
        case (cls)
            4'(PC_MOV):   r = 6'd1;
            4'(PC_MUL):   r = 6'd6;
            4'(PC_MULH):  r = 6'd5;
            4'(PC_MULL):  r = 6'd7;
            4'(PC_MLALD): r = 6'd6;
            4'(PC_LD):    r = 6'd3;
            4'(PC_LDM):   r = 6'd5;
            4'(PC_CALL):  r = 6'd32;
            default:      r = 6'd2;
        endcase
        return r;
    endfunction

    // Wait for a given producer class and consumer use.
    function automatic logic [LAT_W-1:0] use_lat(input logic [3:0] cls, input logic [1:0] use_t);
        logic [LAT_W-1:0] r;
        r = full_lat(cls);
        case (cls)
            4'(PC_MOV): begin
                if (use_t == 2'(CU_LATE) || use_t == 2'(CU_STORE)) r = 6'd0;
            end
            4'(PC_MUL), 4'(PC_MULH): begin
                if (use_t == 2'(CU_LATE)) r = 6'd4;
                else if (use_t == 2'(CU_ACC)) r = 6'd1;
            end
            4'(PC_MULL), 4'(PC_MLALD), 4'(PC_LDM): begin
                if (use_t == 2'(CU_LATE)) r = 6'd4;
            end
            4'(PC_LD): begin
                if (use_t == 2'(CU_LATE)) r = 6'd2;
            end
            4'(PC_CALL): r = 6'd32;
            default: begin
                if (use_t == 2'(CU_LATE)) r = 6'd1;
                else if (use_t == 2'(CU_STORE)) r = 6'd0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sb_entry.sv
module sb_entry
    import sb_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [3:0]    load_cls,
    input  logic [CW-1:0] load_lat,
    output logic [CW-1:0] cnt,
    output logic [3:0]    cls
);

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } ent_state_e;

    ent_state_e state, state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (load && load_lat > CW'(1)) state_nxt = S_WAIT;
            end
            S_WAIT: begin
                if (load)                state_nxt = (load_lat > CW'(1)) ? S_WAIT : S_IDLE;
                else if (cnt == CW'(1))  state_nxt = S_IDLE;
            end
        endcase
    end

    // Outputs: remaining count and producer class
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            cls <= 4'(PC_ALU);
        end else if (load) begin
            cnt <= (load_lat == '0) ? '0 : load_lat - CW'(1);
            cls <= load_cls;
        end else if (state == S_WAIT) begin
            cnt <= cnt - CW'(1);
        end
    end

    // R2: a running count drops by one per cycle
    a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !load) |=> (cnt == $past(cnt) - CW'(1)));

    // R9: a new issue replaces whatever was counting
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_lat != '0) |=> (cnt == $past(load_lat) - CW'(1) && cls == $past(load_cls)));

endmodule

// File: rtl/sb_src_check.sv
module sb_src_check
    import sb_pkg::*;
#(
    parameter int NREG = 16,
    parameter int CW   = 6,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       valid,
    input  logic [RW-1:0]              rsel,
    input  logic [1:0]                 use_t,
    input  logic [NREG-1:0][CW-1:0]    cnts,
    input  logic [NREG-1:0][3:0]       clss,
    input  logic                       prod_valid,
    input  logic [RW-1:0]              prod_reg,
    input  logic [3:0]                 prod_cls,
    output logic                       ready
);

    logic [CW-1:0]    cnt_sel;
    logic [3:0]       cls_sel;
    logic [LAT_W-1:0] thr;

    always_comb begin
        cnt_sel = cnts[rsel];
        cls_sel = clss[rsel];
        thr     = full_lat(cls_sel) - use_lat(cls_sel, use_t);
        if (!valid)
            ready = 1'b1;
        else if (prod_valid && prod_reg == rsel)
            ready = (use_lat(prod_cls, use_t) == '0);
        else
            ready = (cnt_sel <= CW'(thr));
    end

    // R10: an unused operand never holds the consumer
    a_r10_invalid_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ready);

    // R8: move into a late ALU operand pairs in the same cycle
    a_r8_same_cycle_mov: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && prod_valid && prod_reg == rsel && prod_cls == 4'(PC_MOV)
         && use_t == 2'(CU_LATE)) |-> ready);

endmodule

// File: rtl/latency_scoreboard.sv
module latency_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NSRC = 3,
    parameter int CW   = 6,
    localparam int RW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prod_valid,
    input  logic [RW-1:0]      prod_reg,
    input  logic [3:0]         prod_class,
    input  logic [NSRC-1:0]    src_valid,
    input  logic [NSRC*RW-1:0] src_reg,
    input  logic [NSRC*2-1:0]  src_use,
    output logic [NSRC-1:0]    src_ready,
    output logic               stall
);

    logic [NREG-1:0][CW-1:0] cnts;
    logic [NREG-1:0][3:0]    clss;
    logic [CW-1:0]           prod_lat;

    assign prod_lat = CW'(full_lat(prod_class));

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        sb_entry #(.CW(CW)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (prod_valid && prod_reg == RW'(g)),
            .load_cls (prod_class),
            .load_lat (prod_lat),
            .cnt      (cnts[g]),
            .cls      (clss[g])
        );
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        sb_src_check #(.NREG(NREG), .CW(CW)) u_chk (
            .clk        (clk),
            .rst_n      (rst_n),
            .valid      (src_valid[s]),
            .rsel       (src_reg[s*RW +: RW]),
            .use_t      (src_use[s*2 +: 2]),
            .cnts       (cnts),
            .clss       (clss),
            .prod_valid (prod_valid),
            .prod_reg   (prod_reg),
            .prod_cls   (prod_class),
            .ready      (src_ready[s])
        );
    end

    assign stall = ~&src_ready;

    // R7: the cycle after a call, its destination is still blocked
    a_r7_call_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(prod_valid) && $past(prod_class) == 4'(PC_CALL) && src_valid[0]
         && src_reg[RW-1:0] == $past(prod_reg)
         && !(prod_valid && prod_reg == src_reg[RW-1:0])) |-> (!src_ready[0] && stall));

endmodule

// File: tb/sim_latency_scoreboard.sv
`timescale 1ns/1ps
module sim_latency_scoreboard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pv = 1'b0;
    logic [3:0]  pr = '0;
    logic [3:0]  pc = '0;
    logic [2:0]  sv = '0;
    logic [11:0] sr = '0;
    logic [5:0]  su = '0;
    logic [2:0]  rdy;
    logic        stl;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    int  iss_cyc [16];
    int  iss_cls [16];
    bit  iss_any [16];

    always #5 clk = ~clk;

    latency_scoreboard u0 (
        .clk(clk), .rst_n(rst_n), .prod_valid(pv), .prod_reg(pr), .prod_class(pc),
        .src_valid(sv), .src_reg(sr), .src_use(su), .src_ready(rdy), .stall(stl)
    );

    // Latency table from the requirements
    function automatic int exp_lat(input int c, input int u);
        case (c)
            1: return (u == 1 || u == 2) ? 0 : 1;
            2, 3: return (u == 1) ? 4 : (u == 3) ? 1 : (c == 2 ? 6 : 5);
            4: return (u == 1) ? 4 : 7;
            5: return (u == 1) ? 4 : 6;
            6: return (u == 1) ? 2 : 3;
            7: return (u == 1) ? 4 : 5;
            8: return 32;
            default: return (u == 0 || u == 3) ? 2 : (u == 1) ? 1 : 0;
        endcase
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4, 5: return "R5";
            6, 7: return "R6";
            8: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0b expected=%0b", tag, cyc, act, expv);
        end
    endtask

    // Check current inputs, then advance one clock
    task automatic step(input string force_tag);
        logic exp_stall;
        #1;
        exp_stall = 1'b0;
        for (int i = 0; i < 3; i++) begin
            int r;
            int u;
            logic e;
            string t;
            r = int'(sr[i*4 +: 4]);
            u = int'(su[i*2 +: 2]);
            if (!sv[i]) begin
                e = 1'b1; t = "R10";
            end else if (pv && pr == sr[i*4 +: 4]) begin
                e = (exp_lat(int'(pc), u) == 0); t = "R8";
            end else if (!iss_any[r]) begin
                e = 1'b1; t = "R1";
            end else begin
                e = ((cyc - iss_cyc[r]) >= exp_lat(iss_cls[r], u));
                t = tag_of(iss_cls[r]);
            end
            if (force_tag != "") t = force_tag;
            if (!e) exp_stall = 1'b1;
            check_bit(t, rdy[i], e);
        end
        check_bit("R10", stl, exp_stall);
        @(posedge clk);
        if (pv) begin
            iss_any[pr] = 1'b1;
            iss_cyc[pr] = cyc;
            iss_cls[pr] = int'(pc);
        end
        cyc++;
        @(negedge clk);
    endtask

    initial begin
        int classes [10] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 12};
        void'($urandom(32'd2024));
        for (int r = 0; r < 16; r++) begin
            iss_any[r] = 1'b0; iss_cyc[r] = 0; iss_cls[r] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything settled after reset
        sv = 3'b111; sr = {4'd15, 4'd7, 4'd0}; su = {2'd3, 2'd0, 2'd0};
        step("R1");
        su = {2'd1, 2'd2, 2'd3};
        step("R1");

        // R2..R8, R10: every class against every use, from the issue cycle on
        foreach (classes[ci]) begin
            for (int u = 0; u < 4; u++) begin
                pv = 1'b1; pr = 4'd5; pc = 4'(classes[ci]);
                sv = 3'b001; sr = {8'd0, 4'd5}; su = {4'd0, 2'(u)};
                step("");
                pv = 1'b0;
                for (int k = 0; k < exp_lat(classes[ci], u) + 2; k++) step("");
                sv = 3'b000;
                repeat (33) step("");
            end
        end

        // R9: long multiply overwritten by an ALU result one cycle later
        pv = 1'b1; pr = 4'd3; pc = 4'd4; sv = 3'b000;
        step("R9");
        pc = 4'd0; sv = 3'b001; sr = {8'd0, 4'd3}; su = 6'd0;
        step("R9");
        pv = 1'b0;
        repeat (4) step("R9");

        // R9: call overwritten by a move
        pv = 1'b1; pr = 4'd9; pc = 4'd8; sv = 3'b000;
        step("R9");
        pv = 1'b0;
        repeat (3) step("");
        pv = 1'b1; pc = 4'd1;
        step("R9");
        pv = 1'b0; sv = 3'b111; sr = {4'd9, 4'd9, 4'd9}; su = {2'd3, 2'd1, 2'd0};
        repeat (2) step("R9");

        // Random traffic on a narrow register range
        for (int n = 0; n < 4000; n++) begin
            pv = ($urandom_range(0, 3) != 0);
            pr = 4'($urandom_range(0, 5));
            pc = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
            if (pc == 4'd8 && $urandom_range(0, 3) != 0) pc = 4'd0;
            sv = 3'($urandom_range(0, 7));
            sr = {4'($urandom_range(0, 5)), 4'($urandom_range(0, 5)), 4'($urandom_range(0, 5))};
            su = 6'($urandom_range(0, 63));
            step("");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule